// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a general-purpose I/O bank with 32 pins by default. A host reaches it through one word-addressed read/write port. Each pin has a direction bit and an output latch. A host changes them only by writing masks to separate set and clear addresses, so it never needs a read-modify-write sequence. The level of every pin is synchronised and can be read back at any time.

Each pin also has an interrupt detector. Three configuration bits per pin choose the trigger:
- kind: edge or level
- edge count: single or both
- polarity: positive or negative

A detected event latches a pending bit in a status register, and the host acknowledges it by writing one to that bit. Per-pin enables gate the pending bits onto a single host interrupt line. Pending bits keep latching while a pin is disabled.

The register map uses word addresses:

| Address | Access | Content |
|---|---|---|
| 0 | read | direction, 1 = output |
| 1 | write | direction set |
| 2 | write | direction clear |
| 3 | read | output latches |
| 4 | write | output set |
| 5 | write | output clear |
| 6 | read | input levels |
| 7 | read, write-one-to-clear | pending status |
| 8 | read | enables |
| 9 | write | enable set |
| 10 | write | enable clear |
| 11 | read/write | trigger kind |
| 12 | read/write | edge count |
| 13 | read/write | polarity |

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every pin is an input (address 0 reads 0 and `pin_oe` is 0). The output latches, enables, pending bits and configuration bits are all 0, and `irq` is low.
- R2: Address 0 returns the direction of every pin, with 1 meaning output. `pin_oe` carries the same bits.
- R3: Writing a mask to address 1 makes each pin with a 1 bit an output. Writing a mask to address 2 makes each such pin an input. Pins whose mask bit is 0 keep their direction.
- R4: Writing a mask to address 4 sets the selected output latches high, and a mask to address 5 sets them low. Unselected latches keep their value. Address 3 and `pin_out` show the latches.
- R5: Address 6 returns each pin's level after a two-flop synchroniser, whatever the pin's direction.
- R6: Address 7 returns the pending bits. Writing to it clears each bit written as 1 and leaves bits written as 0 untouched.
- R7: Writing a mask to address 9 sets the selected enables, and a mask to address 10 clears them. Address 8 returns the enables.
- R8: Addresses 11, 12 and 13 are plain read/write registers:
  - address 11, trigger kind: 1 = edge, 0 = level
  - address 12, edge count: 1 = both edges, 0 = single
  - address 13, polarity: 1 = negative/low, 0 = positive/high

  The write-only set and clear addresses read as 0.
- R9: In edge mode the pending bit sets only on a new qualifying edge of the synchronised level. With a single edge this is rising for positive polarity and falling for negative polarity. With both edges it is either edge, and polarity is ignored. Holding a level after an acknowledge does not set the bit again.
- R10: In level mode the pending bit sets while the synchronised level matches the polarity (high or low). It sets again in the cycle after an acknowledge while that level persists.
- R11: When an acknowledge and a new event for the same pin fall in the same cycle, the pending bit stays set.
- R12: `irq` is high exactly when some pin has both its pending bit and its enable set. Pending bits latch even while their enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Word address of the access |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data or mask |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latches |
| pin_oe | output | 32 | Output enables (direction) |
| irq | output | 1 | Combined interrupt to the host |

## Verification
The default configuration is level-high, so the first pattern drives a mixed word onto the pins. That single pattern shows the input register, level latching, and re-latching after a partial acknowledge. A per-pin mix of rising, falling, both-edge and level-low modes is then exercised:
- raising and lowering several pins at once separates the rising, falling and both-edge cells, since each responds to a different subset of the transitions;
- a rise on a falling-mode pin shows that the wrong edge is ignored;
- holding the level after an acknowledge separates edge mode from level mode.

An edge timed to land in the same cycle as its acknowledge shows that the event takes priority over the clear. Enable-set and enable-clear writes around a pending bit show that `irq` is gated while latching continues.

// File: rtl/gpio_bank_pkg.sv
// Shared address map and per-pin trigger configuration type for the GPIO bank.
package gpio_bank_pkg;

    localparam int ADDR_W = 4;

    // Word addresses of the register port.
    typedef enum logic [ADDR_W-1:0] {
        A_DIR     = 4'd0,
        A_DIR_SET = 4'd1,
        A_DIR_CLR = 4'd2,
        A_OUT     = 4'd3,
        A_OUT_SET = 4'd4,
        A_OUT_CLR = 4'd5,
        A_IN      = 4'd6,
        A_STAT    = 4'd7,
        A_EN      = 4'd8,
        A_EN_SET  = 4'd9,
        A_EN_CLR  = 4'd10,
        A_KIND    = 4'd11,
        A_BOTH    = 4'd12,
        A_POL     = 4'd13
    } reg_addr_e;

    // Per-pin trigger configuration.
    typedef struct packed {
        logic edge_kind;   // 1 = edge, 0 = level
        logic both;        // 1 = both edges
        logic neg;         // 1 = falling / low
    } trig_cfg_t;

endpackage

// File: rtl/gpio_pin_sync.sv
// gpio_pin_sync: multi-flop synchroniser for asynchronous pin levels, plus one
// further register holding the previous synchronised sample for edge finding.
// Assumes STAGES >= 2. Reset values are 0.
module gpio_pin_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] level,
    output logic [NPINS-1:0] prev
);
    logic [STAGES-1:0][NPINS-1:0] chain_q;
    logic [NPINS-1:0]             prev_q;

    // Shift pin levels through the chain and keep the last synchronised sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign prev  = prev_q;
endmodule

// File: rtl/gpio_ctrl_regs.sv
// gpio_ctrl_regs: register file of the GPIO bank. Holds direction, output
// latches and enables, which change only through set/clear masks, and the three
// per-pin trigger configuration words. It decodes the acknowledge mask and
// provides the combinational read mux. Assumes one access per cycle.
module gpio_ctrl_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [NPINS-1:0]  wdata,
    input  logic [NPINS-1:0]  level,
    input  logic [NPINS-1:0]  pend,
    output logic [NPINS-1:0]  rdata,
    output logic [NPINS-1:0]  dir,
    output logic [NPINS-1:0]  out,
    output logic [NPINS-1:0]  en,
    output logic [NPINS-1:0]  kind,
    output logic [NPINS-1:0]  both,
    output logic [NPINS-1:0]  neg,
    output logic [NPINS-1:0]  ack_mask
);
    reg_addr_e        a;
    logic [NPINS-1:0] dir_q, out_q, en_q, kind_q, both_q, neg_q;

    assign a = reg_addr_e'(addr);

    // Direction: set/clear masks only.
    always_ff @(posedge clk) begin
        if (!rst_n)                   dir_q <= '0;
        else if (wr && a == A_DIR_SET) dir_q <= dir_q | wdata;
        else if (wr && a == A_DIR_CLR) dir_q <= dir_q & ~wdata;
    end

    // Output latches: set/clear masks only.
    always_ff @(posedge clk) begin
        if (!rst_n)                   out_q <= '0;
        else if (wr && a == A_OUT_SET) out_q <= out_q | wdata;
        else if (wr && a == A_OUT_CLR) out_q <= out_q & ~wdata;
    end

    // Interrupt enables: set/clear masks only.
    always_ff @(posedge clk) begin
        if (!rst_n)                  en_q <= '0;
        else if (wr && a == A_EN_SET) en_q <= en_q | wdata;
        else if (wr && a == A_EN_CLR) en_q <= en_q & ~wdata;
    end

    // Trigger configuration words: plain writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= '0;
            both_q <= '0;
            neg_q  <= '0;
        end else if (wr) begin
            if (a == A_KIND) kind_q <= wdata;
            if (a == A_BOTH) both_q <= wdata;
            if (a == A_POL)  neg_q  <= wdata;
        end
    end

    // Read mux; write-only addresses read as zero.
    always_comb begin
        case (a)
            A_DIR:   rdata = dir_q;
            A_OUT:   rdata = out_q;
            A_IN:    rdata = level;
            A_STAT:  rdata = pend;
            A_EN:    rdata = en_q;
            A_KIND:  rdata = kind_q;
            A_BOTH:  rdata = both_q;
            A_POL:   rdata = neg_q;
            default: rdata = '0;
        endcase
    end

    assign ack_mask = (wr && a == A_STAT) ? wdata : '0;
    assign dir  = dir_q;
    assign out  = out_q;
    assign en   = en_q;
    assign kind = kind_q;
    assign both = both_q;
    assign neg  = neg_q;

    // R3: a direction-set write turns every selected pin into an output.
    a_r3_dir_set_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && a == A_DIR_SET) |=> ((dir_q & $past(wdata)) == $past(wdata)));
    // R3: a direction-set write leaves unselected pins unchanged.
    a_r3_dir_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && a == A_DIR_SET) |=> ((dir_q & ~$past(wdata)) == ($past(dir_q) & ~$past(wdata))));
    // R4: an output-clear write drives the selected latches low.
    a_r4_out_clr_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && a == A_OUT_CLR) |=> ((out_q & $past(wdata)) == '0));
    // R7: enables hold when no enable write occurs.
    a_r7_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (a == A_EN_SET || a == A_EN_CLR)) |=> $stable(en_q));
endmodule

// File: rtl/gpio_irq_detect.sv
// gpio_irq_detect: per-pin trigger decoding and pending latch, plus the combined
// host interrupt. Assumes level/prev come from a synchroniser. A new event has
// priority over an acknowledge in the same cycle.
module gpio_irq_detect
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] level,
    input  logic [NPINS-1:0] prev,
    input  logic [NPINS-1:0] kind,
    input  logic [NPINS-1:0] both,
    input  logic [NPINS-1:0] neg,
    input  logic [NPINS-1:0] ack_mask,
    input  logic [NPINS-1:0] en,
    output logic [NPINS-1:0] pend,
    output logic             irq
);
    logic [NPINS-1:0] evt;
    logic [NPINS-1:0] pend_q;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        trig_cfg_t cfg;
        logic      changed;
        logic      active;

        assign cfg     = '{edge_kind: kind[i], both: both[i], neg: neg[i]};
        assign changed = level[i] ^ prev[i];
        assign active  = level[i] ^ cfg.neg;

        // Event decode for this pin's trigger mode.
        always_comb begin
            if (!cfg.edge_kind)  evt[i] = active;
            else if (cfg.both)   evt[i] = changed;
            else                 evt[i] = changed & active;
        end

        // R9: a pending bit rises only after an event was seen.
        a_r9_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q[i]) |-> $past(evt[i]));
        // R11: an event beats an acknowledge in the same cycle.
        a_r11_event_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_mask[i] && evt[i]) |=> pend_q[i]);
        // R10: an active level in level mode keeps the pending bit set.
        a_r10_level_refire: assert property (@(posedge clk) disable iff (!rst_n)
            (!kind[i] && (level[i] ^ neg[i])) |=> pend_q[i]);
    end

    // Pending latch: acknowledge clears, new events set.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~ack_mask) | evt;
    end

    assign pend = pend_q;
    assign irq  = |(pend_q & en);

    // R12: the host line is never raised without a pending bit.
    a_r12_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend_q != '0));
endmodule

// File: rtl/gpio_irq_bank.sv
// gpio_irq_bank: top of the GPIO bank. Joins the pin synchroniser, the register
// file and the interrupt detector. Assumes asynchronous pin inputs and a
// single-cycle register port.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] level, prev, pend, en, kind, both, neg, ack_mask;

    gpio_pin_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .level(level), .prev(prev)
    );

    gpio_ctrl_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
        .level(level), .pend(pend), .rdata(reg_rdata), .dir(pin_oe), .out(pin_out),
        .en(en), .kind(kind), .both(both), .neg(neg), .ack_mask(ack_mask)
    );

    gpio_irq_detect #(.NPINS(NPINS)) u_det (
        .clk(clk), .rst_n(rst_n), .level(level), .prev(prev), .kind(kind),
        .both(both), .neg(neg), .ack_mask(ack_mask), .en(en), .pend(pend), .irq(irq)
    );
endmodule

// File: tb/gpio_irq_bank_bench.sv
// Scoreboard bench: the driver queues expected items, the monitor compares them.
module gpio_irq_bank_bench;
    localparam int N = 32;

    typedef struct {
        int          kind;   // 0 rdata, 1 irq, 2 pin_oe, 3 pin_out
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [N-1:0]  reg_wdata = '0;
    logic [N-1:0]  reg_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe;
    logic          irq;

    sb_item_t sb_q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_irq_bank u_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Monitor: pop queued expectations just after each falling edge.
    initial forever begin
        @(negedge clk);
        #1;
        while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = reg_rdata;
                1:       act = {31'd0, irq};
                2:       act = pin_oe;
                default: act = pin_out;
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %08h expected %08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        sb_item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic chk_reg(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        push(0, exp, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic drive_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk_reg(4'd0, 32'h0, "R1 dir after reset");
        push(2, 32'h0, "R1 pin_oe after reset");
        push(1, 32'h0, "R1 irq after reset");
        chk_reg(4'd7, 32'h0, "R1 status after reset");
        chk_reg(4'd8, 32'h0, "R1 enable after reset");
        chk_reg(4'd11, 32'h0, "R1 kind after reset");

        // R2/R3 direction
        wr(4'd1, 32'h0000_00F0);
        chk_reg(4'd0, 32'h0000_00F0, "R3 dir set");
        push(2, 32'h0000_00F0, "R2 pin_oe follows dir");
        wr(4'd2, 32'h0000_0030);
        chk_reg(4'd0, 32'h0000_00C0, "R3 dir clear keeps others");
        chk_reg(4'd1, 32'h0, "R8 set address reads zero");

        // R4 outputs
        wr(4'd4, 32'h0000_00A5);
        chk_reg(4'd3, 32'h0000_00A5, "R4 out set");
        push(3, 32'h0000_00A5, "R4 pin_out");
        wr(4'd5, 32'h0000_0005);
        chk_reg(4'd3, 32'h0000_00A0, "R4 out clear");

        // R5 input, default level-high latching (R10), R6 ack
        drive_pins(32'h1234_5678);
        chk_reg(4'd6, 32'h1234_5678, "R5 input register");
        chk_reg(4'd7, 32'h1234_5678, "R10 level-high default latches");
        wr(4'd7, 32'h0000_0078);
        chk_reg(4'd7, 32'h1234_5678, "R10 level re-latches after ack");
        drive_pins(32'h0);
        chk_reg(4'd7, 32'h1234_5678, "R6 pending held until ack");
        wr(4'd7, 32'hFFFF_FFFF);
        chk_reg(4'd7, 32'h0, "R6 ack clears all");

        // R8 configuration: pin0 rise, pin1 fall, pin2 both, pin3 level-low
        wr(4'd11, 32'h0000_0007);
        wr(4'd12, 32'h0000_0004);
        wr(4'd13, 32'h0000_000E);
        repeat (2) @(posedge clk);
        chk_reg(4'd13, 32'h0000_000E, "R8 polarity readback");
        chk_reg(4'd7, 32'h0000_0008, "R10 level-low latches");
        wr(4'd7, 32'h0000_0008);
        chk_reg(4'd7, 32'h0000_0008, "R10 level-low refires");
        drive_pins(32'h0000_0008);
        wr(4'd7, 32'h0000_0008);
        chk_reg(4'd7, 32'h0, "R10 inactive level stays clear");

        // R9 edge modes
        drive_pins(32'h0000_000D);
        chk_reg(4'd7, 32'h0000_0005, "R9 rising and both on rise");
        wr(4'd7, 32'h0000_0001);
        chk_reg(4'd7, 32'h0000_0004, "R6 partial ack, R9 no refire");
        wr(4'd7, 32'h0000_0004);
        drive_pins(32'h0000_0008);
        chk_reg(4'd7, 32'h0000_0004, "R9 fall sets only both-edge pin");
        wr(4'd7, 32'h0000_0004);
        drive_pins(32'h0000_000A);
        chk_reg(4'd7, 32'h0, "R9 falling pin ignores rise");
        drive_pins(32'h0000_0008);
        chk_reg(4'd7, 32'h0000_0002, "R9 falling pin on fall");

        // R7/R12 enables and host line
        push(1, 32'h0, "R12 pending but disabled");
        wr(4'd9, 32'h0000_0002);
        chk_reg(4'd8, 32'h0000_0002, "R7 enable set");
        push(1, 32'h1, "R12 irq raised when enabled");
        wr(4'd7, 32'h0000_0002);
        chk_reg(4'd7, 32'h0, "R6 ack bit1");
        push(1, 32'h0, "R12 irq drops after ack");
        wr(4'd9, 32'h0000_0005);
        wr(4'd10, 32'h0000_0004);
        chk_reg(4'd8, 32'h0000_0003, "R7 enable clear");

        // R11 event beats ack
        drive_pins(32'h0000_0009);
        chk_reg(4'd7, 32'h0000_0001, "R9 rise pending again");
        drive_pins(32'h0000_0008);
        @(negedge clk);
        pin_in = 32'h0000_0009;
        @(posedge clk);
        @(posedge clk);
        wr(4'd7, 32'h0000_0001);
        chk_reg(4'd7, 32'h0000_0001, "R11 event wins over ack");
        push(1, 32'h1, "R12 irq stays with pending");
        wr(4'd7, 32'h0000_0001);
        chk_reg(4'd7, 32'h0, "R6 ack after collision");
        push(1, 32'h0, "R12 irq clear");

        @(negedge clk);
        #2;
        done = 1;
        finish_run();
    end
endmodule